// File: doc/BRIEF.md
# Link Rate and Lane Count Selector

This block chooses the serial link configuration for a display stream. Given a pixel clock in kHz, the bits per colour component, and the sink's limits, it picks the slowest link rate and the smallest lane count that carry the stream. It also reports whether the chosen configuration is legal for that sink. Display setup logic pulses `start` with the mode's parameters held on the inputs. Some time later it sees a one-cycle `done`, and the three result outputs are then valid. They stay valid until the next result.

The search is sequential and uses no divider. Each trial compares `pixel_clock * bits_per_pixel` with `rate * lanes * 8`, where the right side is a shift of the rate. The controller has three states. `ST_IDLE` waits for `start` and captures the inputs (transition IDLE→LANE). `ST_LANE` tests 1, 2 and then 4 lanes at the sink's maximum rate, one count per cycle (LANE→LANE on a miss, LANE→RATE on a fit or when the sink's lane limit is reached). `ST_RATE` tests the candidate rates in rising order at the chosen lane count, one per cycle (RATE→RATE on a miss, RATE→IDLE when a rate is chosen, which registers the results and raises `done`). A force input skips the rate search and pins the rate at the middle value.

Top module: `link_cfg_select`

## Requirements
- R1: Bits per pixel is 24 when `bpc` is 0; otherwise it is three times `bpc`.
- R2: A rate R with L lanes carries the mode when `pix_khz * bpp <= R * L * 8`. Equality counts as a fit. This is the same as the pixel clock being at most the floor of `R * L * 8 / bpp`.
- R3: Lane counts are tried in the order 1, 2, 4 at `sink_rate_max`, and the first count that fits is kept. The search stops without a test at the first count that is not below `sink_lanes_max`, and that count is taken. A limit above 4 acts as 4.
- R4: At the chosen lane count, 162000 is tried first and then 270000. 540000 is tried next only when `sink_hi_rate_ok` is 1. The first rate that fits is selected. If none fits, `sink_rate_max` is selected.
- R5: `mode_ok` is 0 exactly when the selected rate is 540000 and `sink_hi_rate_ok` was 0 at `start`. Otherwise it is 1.
- R6: When `force_mid_rate` is 1 at `start`, the selected rate is 270000 whatever the pixel clock. The lane count is still chosen as in R3, and `mode_ok` is 1.
- R7: `done` is high for exactly one cycle. It rises N clock edges after the edge that samples `start`. N is the number of lane trials plus the number of rate trials. A forced rate counts as one rate trial. Falling back to the sink maximum counts as 3 rate trials without high-rate support and 4 with it.
- R8: A `start` pulse that arrives while a search is running is ignored. It does not change that search's result or timing, and it produces no second `done`.
- R9: After reset, `done`, `sel_rate`, `sel_lanes` and `mode_ok` are all 0. The results change only at the edge where `done` rises and hold otherwise.
- R10: `sel_lanes` is the lane count in plain binary: 1, 2 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; the mode inputs are captured when it is sampled in idle |
| pix_khz | input | PIX_W | Pixel clock in kHz |
| bpc | input | BPC_W | Bits per colour component; 0 means 8 |
| sink_rate_max | input | RATE_W | Sink's maximum link rate in kHz |
| sink_lanes_max | input | MAX_LANE_SH+1 | Sink's maximum lane count |
| sink_hi_rate_ok | input | 1 | Sink accepts the 540000 rate |
| force_mid_rate | input | 1 | Select 270000 regardless of the pixel clock |
| done | output | 1 | One-cycle pulse when the results are updated |
| sel_rate | output | RATE_W | Selected link rate in kHz |
| sel_lanes | output | MAX_LANE_SH+1 | Selected lane count |
| mode_ok | output | 1 | Configuration is legal for the sink |

## Verification
The results are due at a fixed time for each mode. The bench's model counts the lane trials and rate trials from the requirements, and from them works out the edge at which `done` must rise. At every falling clock edge after `start`, the bench compares `done` against that count. It checks that `done` is low at every other edge, and it checks the result outputs from the due edge through two further cycles. The checks include a `start` pulse sent during a running search, cases at the exact limit of the fit inequality, and each fallback path, so that an extra or missing trial shifts `done` and is reported.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LANE = 2'd1,
        ST_RATE = 2'd2
    } lcs_state_t;
endpackage

// File: rtl/lcs_demand.sv
// Bandwidth demand: pixel clock times bits per pixel.
module lcs_demand #(
    parameter int PIX_W = 20,
    parameter int BPC_W = 4,
    parameter int BPP_W = 6,
    parameter int DEM_W = PIX_W + BPP_W
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [BPC_W-1:0] bpc,
    output logic [DEM_W-1:0] demand
);
    logic [BPP_W-1:0] bpp;

    always_comb begin
        if (bpc == '0)
            bpp = BPP_W'(24);
        else
            bpp = BPP_W'(bpc) + (BPP_W'(bpc) << 1);
        demand = DEM_W'(pix) * DEM_W'(bpp);
    end
endmodule

// File: rtl/lcs_fit.sv
// Capacity test: demand <= rate * (1 << lane_sh) * 8, done with shifts only.
module lcs_fit #(
    parameter int DEM_W  = 26,
    parameter int RATE_W = 20,
    parameter int SH_W   = 2,
    parameter int CMP_W  = 48
) (
    input  logic [DEM_W-1:0]  demand,
    input  logic [RATE_W-1:0] rate,
    input  logic [SH_W-1:0]   lane_sh,
    output logic              fits
);
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] capacity;

    always_comb begin
        base     = CMP_W'(rate);
        capacity = (base << 3) << lane_sh;
        fits     = (CMP_W'(demand) <= capacity);
    end
endmodule

// File: rtl/lcs_rate_pick.sv
// Candidate rate for the current rate trial, and whether it is taken untested.
module lcs_rate_pick #(
    parameter int RATE_W   = 20,
    parameter int RATE_LO  = 162000,
    parameter int RATE_MID = 270000,
    parameter int RATE_HI  = 540000
) (
    input  logic [1:0]        rate_ix,
    input  logic              hi_ok,
    input  logic              force_mid,
    input  logic [RATE_W-1:0] rate_max,
    output logic [RATE_W-1:0] cand,
    output logic              no_test
);
    always_comb begin
        cand    = RATE_W'(RATE_LO);
        no_test = 1'b0;
        if (force_mid) begin
            cand    = RATE_W'(RATE_MID);
            no_test = 1'b1;
        end else begin
            unique case (rate_ix)
                2'd0: cand = RATE_W'(RATE_LO);
                2'd1: cand = RATE_W'(RATE_MID);
                2'd2: begin
                    if (hi_ok) begin
                        cand = RATE_W'(RATE_HI);
                    end else begin
                        cand    = rate_max;
                        no_test = 1'b1;
                    end
                end
                default: begin
                    cand    = rate_max;
                    no_test = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/link_cfg_select.sv
module link_cfg_select
    import lcs_pkg::*;
#(
    parameter int PIX_W       = 20,
    parameter int BPC_W       = 4,
    parameter int RATE_W      = 20,
    parameter int MAX_LANE_SH = 2,
    parameter int RATE_LO     = 162000,
    parameter int RATE_MID    = 270000,
    parameter int RATE_HI     = 540000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [PIX_W-1:0]       pix_khz,
    input  logic [BPC_W-1:0]       bpc,
    input  logic [RATE_W-1:0]      sink_rate_max,
    input  logic [MAX_LANE_SH:0]   sink_lanes_max,
    input  logic                   sink_hi_rate_ok,
    input  logic                   force_mid_rate,
    output logic                   done,
    output logic [RATE_W-1:0]      sel_rate,
    output logic [MAX_LANE_SH:0]   sel_lanes,
    output logic                   mode_ok
);
    localparam int LANE_W = MAX_LANE_SH + 1;
    localparam int SH_W   = (MAX_LANE_SH > 1) ? $clog2(MAX_LANE_SH + 1) : 1;
    localparam int BPP_W  = (BPC_W + 2 > 5) ? BPC_W + 2 : 5;
    localparam int DEM_W  = PIX_W + BPP_W;
    localparam int CMP_W  = DEM_W + RATE_W + MAX_LANE_SH + 3;

    lcs_state_t state_q, state_d;

    // Captured request
    logic [PIX_W-1:0]  pix_q;
    logic [BPC_W-1:0]  bpc_q;
    logic [RATE_W-1:0] rmax_q;
    logic [LANE_W-1:0] lmax_q;
    logic              hi_q;
    logic              force_q;

    // Search position
    logic [SH_W-1:0]   lane_sh_q;
    logic [1:0]        rate_ix_q;

    logic [DEM_W-1:0]  demand;
    logic [RATE_W-1:0] cand;
    logic              no_test;
    logic [RATE_W-1:0] cmp_rate;
    logic              fits;
    logic [LANE_W-1:0] lane_cnt;
    logic              lane_cap;
    logic              lane_stop;
    logic              rate_stop;

    lcs_demand #(
        .PIX_W (PIX_W),
        .BPC_W (BPC_W),
        .BPP_W (BPP_W),
        .DEM_W (DEM_W)
    ) u_demand (
        .pix    (pix_q),
        .bpc    (bpc_q),
        .demand (demand)
    );

    lcs_rate_pick #(
        .RATE_W   (RATE_W),
        .RATE_LO  (RATE_LO),
        .RATE_MID (RATE_MID),
        .RATE_HI  (RATE_HI)
    ) u_rate_pick (
        .rate_ix   (rate_ix_q),
        .hi_ok     (hi_q),
        .force_mid (force_q),
        .rate_max  (rmax_q),
        .cand      (cand),
        .no_test   (no_test)
    );

    // Lane trials run at the sink maximum, rate trials at the candidate.
    assign cmp_rate = (state_q == ST_LANE) ? rmax_q : cand;

    lcs_fit #(
        .DEM_W  (DEM_W),
        .RATE_W (RATE_W),
        .SH_W   (SH_W),
        .CMP_W  (CMP_W)
    ) u_fit (
        .demand  (demand),
        .rate    (cmp_rate),
        .lane_sh (lane_sh_q),
        .fits    (fits)
    );

    always_comb begin
        lane_cnt  = LANE_W'(1) << lane_sh_q;
        lane_cap  = (lane_sh_q == SH_W'(MAX_LANE_SH)) || (lane_cnt >= lmax_q);
        lane_stop = lane_cap || fits;
        rate_stop = no_test || fits;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_LANE;
            ST_LANE: if (lane_stop) state_d = ST_RATE;
            ST_RATE: if (rate_stop) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Request capture and search position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q     <= '0;
            bpc_q     <= '0;
            rmax_q    <= '0;
            lmax_q    <= '0;
            hi_q      <= 1'b0;
            force_q   <= 1'b0;
            lane_sh_q <= '0;
            rate_ix_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pix_q     <= pix_khz;
                        bpc_q     <= bpc;
                        rmax_q    <= sink_rate_max;
                        lmax_q    <= sink_lanes_max;
                        hi_q      <= sink_hi_rate_ok;
                        force_q   <= force_mid_rate;
                        lane_sh_q <= '0;
                        rate_ix_q <= '0;
                    end
                end
                ST_LANE: begin
                    if (!lane_stop)
                        lane_sh_q <= lane_sh_q + SH_W'(1);
                end
                ST_RATE: begin
                    if (!rate_stop)
                        rate_ix_q <= rate_ix_q + 2'd1;
                end
                default: ;
            endcase
        end
    end

    // Registered results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            sel_rate  <= '0;
            sel_lanes <= '0;
            mode_ok   <= 1'b0;
        end else begin
            done <= 1'b0;
            if ((state_q == ST_RATE) && rate_stop) begin
                done      <= 1'b1;
                sel_rate  <= cand;
                sel_lanes <= lane_cnt;
                mode_ok   <= !((cand == RATE_W'(RATE_HI)) && !hi_q);
            end
        end
    end
endmodule

// File: rtl/link_cfg_select_chk.sv
module link_cfg_select_chk
    import lcs_pkg::*;
#(
    parameter int RATE_W   = 20,
    parameter int LANE_W   = 3,
    parameter int RATE_MID = 270000,
    parameter int RATE_HI  = 540000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [RATE_W-1:0] sel_rate,
    input logic [LANE_W-1:0] sel_lanes,
    input logic              mode_ok,
    input logic              force_q,
    input logic [LANE_W-1:0] lmax_q,
    input lcs_state_t        state_q
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(sel_rate) && $stable(sel_lanes) && $stable(mode_ok)));

    // R10
    lane_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(sel_lanes) == 1));

    // R3
    lane_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((sel_lanes <= lmax_q) || (sel_lanes == LANE_W'(1))));

    // R5
    invalid_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_ok) |-> (sel_rate == RATE_W'(RATE_HI)));

    // R6
    forced_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && force_q) |-> ((sel_rate == RATE_W'(RATE_MID)) && mode_ok));

    // R8
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE));
endmodule

bind link_cfg_select link_cfg_select_chk #(
    .RATE_W   (RATE_W),
    .LANE_W   (LANE_W),
    .RATE_MID (RATE_MID),
    .RATE_HI  (RATE_HI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .sel_rate  (sel_rate),
    .sel_lanes (sel_lanes),
    .mode_ok   (mode_ok),
    .force_q   (force_q),
    .lmax_q    (lmax_q),
    .state_q   (state_q)
);

// File: tb/test_link_cfg_select.sv
module test_link_cfg_select;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [19:0] pix_khz;
    logic [3:0]  bpc;
    logic [19:0] sink_rate_max;
    logic [2:0]  sink_lanes_max;
    logic        sink_hi_rate_ok;
    logic        force_mid_rate;
    logic        done;
    logic [19:0] sel_rate;
    logic [2:0]  sel_lanes;
    logic        mode_ok;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_cfg_select i_link_cfg_select (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .pix_khz         (pix_khz),
        .bpc             (bpc),
        .sink_rate_max   (sink_rate_max),
        .sink_lanes_max  (sink_lanes_max),
        .sink_hi_rate_ok (sink_hi_rate_ok),
        .force_mid_rate  (force_mid_rate),
        .done            (done),
        .sel_rate        (sel_rate),
        .sel_lanes       (sel_lanes),
        .mode_ok         (mode_ok)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural model using the division form of the capacity rule.
    task automatic model(input int pix, input int bpc_i, input int rmax,
                         input int lmax, input int hi, input int frc,
                         output int er, output int el, output int eok,
                         output int elat);
        int     bpp;
        int     l;
        int     nl;
        int     nr;
        bit     found;
        int     rates[3];
        longint capk;
        rates[0] = 162000;
        rates[1] = 270000;
        rates[2] = 540000;
        bpp = (bpc_i == 0) ? 24 : bpc_i * 3;
        l  = 1;
        nl = 1;
        while (l < lmax) begin
            capk = (longint'(rmax) * l * 8) / bpp;
            if (pix <= capk) break;
            l  = l * 2;
            nl = nl + 1;
        end
        el = l;
        if (frc != 0) begin
            er = 270000;
            nr = 1;
        end else begin
            found = 1'b0;
            nr = 0;
            for (int i = 0; i < ((hi != 0) ? 3 : 2); i++) begin
                capk = (longint'(rates[i]) * l * 8) / bpp;
                if (!found && pix <= capk) begin
                    found = 1'b1;
                    er = rates[i];
                    nr = i + 1;
                end
            end
            if (!found) begin
                er = rmax;
                nr = (hi != 0) ? 4 : 3;
            end
        end
        eok  = (er == 540000 && hi == 0) ? 0 : 1;
        elat = nl + nr;
    endtask

    task automatic run_case(input string req, input int pix, input int bpc_i,
                            input int rmax, input int lmax, input int hi,
                            input int frc, input bit poke);
        int er, el, eok, elat;
        model(pix, bpc_i, rmax, lmax, hi, frc, er, el, eok, elat);
        @(negedge clk);
        pix_khz         = 20'(pix);
        bpc             = 4'(bpc_i);
        sink_rate_max   = 20'(rmax);
        sink_lanes_max  = 3'(lmax);
        sink_hi_rate_ok = (hi != 0);
        force_mid_rate  = (frc != 0);
        start           = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", "done at start edge", done, 0);
        for (int j = 1; j <= elat + 2; j++) begin
            @(negedge clk);
            check("R7", $sformatf("%s done at edge %0d", req, j), done, (j == elat));
            if (j >= elat) begin
                check(req, "sel_rate", sel_rate, er);
                check("R10", "sel_lanes", sel_lanes, el);
                check("R5", "mode_ok", mode_ok, eok);
            end
            if (poke && j == 1) begin
                // R8: a second request during the search
                start          = 1'b1;
                pix_khz        = 20'd1000;
                bpc            = 4'd6;
                sink_lanes_max = 3'd1;
                force_mid_rate = !force_mid_rate;
            end
            if (poke && j == 2) start = 1'b0;
        end
    endtask

    initial begin
        rst_n           = 1'b0;
        start           = 1'b0;
        pix_khz         = '0;
        bpc             = '0;
        sink_rate_max   = '0;
        sink_lanes_max  = '0;
        sink_hi_rate_ok = 1'b0;
        force_mid_rate  = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "done in reset", done, 0);
        check("R9", "sel_rate in reset", sel_rate, 0);
        check("R9", "sel_lanes in reset", sel_lanes, 0);
        check("R9", "mode_ok in reset", mode_ok, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "done after reset", done, 0);

        run_case("R4", 25000,  8,  270000, 4, 0, 0, 1'b0);
        run_case("R3", 148500, 8,  270000, 4, 0, 0, 1'b0);
        run_case("R4", 148500, 10, 540000, 4, 1, 0, 1'b0);
        run_case("R5", 148500, 10, 540000, 4, 0, 0, 1'b0);
        run_case("R6", 148500, 10, 540000, 4, 0, 1, 1'b0);
        run_case("R1", 100000, 0,  162000, 4, 0, 0, 1'b0);
        run_case("R1", 50000,  15, 162000, 2, 0, 0, 1'b0);
        run_case("R3", 300000, 8,  270000, 1, 0, 0, 1'b0);
        run_case("R3", 600000, 8,  540000, 4, 1, 0, 1'b0);
        run_case("R4", 900000, 8,  540000, 4, 1, 0, 1'b0);
        run_case("R2", 90000,  8,  270000, 4, 0, 0, 1'b0);
        run_case("R2", 90001,  8,  270000, 4, 0, 0, 1'b0);
        run_case("R2", 102857, 7,  270000, 4, 0, 0, 1'b0);
        run_case("R2", 102858, 7,  270000, 4, 0, 0, 1'b0);
        run_case("R6", 400000, 8,  270000, 2, 0, 1, 1'b0);
        run_case("R8", 148500, 10, 540000, 4, 1, 0, 1'b1);
        run_case("R8", 600000, 8,  540000, 4, 1, 0, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule